// File: doc/BRIEF.md
# Parallel Display Bus Transaction Sequencer

This block drives one write transaction on an 8080-style parallel display bus. A transaction is made of up to three phases that always run in a fixed order: a command phase that puts a 32-bit command word on the bus, a dummy phase that drives zero words, and a data phase that forwards words pulled from a ready/valid input stream. Each phase can be switched off on its own. The length of every phase in bus cycles comes from configuration inputs. The block captures these inputs on the clock edge where it accepts a start pulse.

During each phase the block drives the data/command select line to a level chosen for that phase. A separate level applies while the bus is idle. This line can also be delayed by a few clock cycles against the bus words. Data-phase words are 16 bits wide. Before they leave the block, their two bytes can be exchanged and their bit order reversed. On an 8-bit bus each word goes out as two byte cycles, and a control bit selects which byte goes first.

The data phase runs in one of two modes. In counted mode it lasts a programmed number of bus cycles. In streaming mode it lasts for as long as the input stream keeps offering words. Completion is marked by a one-cycle done pulse, and an abort pulse drops any transaction in progress.

Top module: `pbus_seq`

## Requirements
- R1: A start pulse is accepted only while `busy_o` is low. On acceptance the block captures every configuration input, and the first bus cycle of the first enabled phase appears in the cycle after that clock edge. Phases always run in the order command, dummy, data. `busy_o` stays high from that cycle through the done cycle. An idle bus has `wr_o` and `s_ready_o` low.
- R2: Each length input holds the number of bus cycles minus one. `phase_en_i` bit 0 enables the command phase, bit 1 the dummy phase and bit 2 the data phase, and a cleared bit skips that phase. With no phase enabled, `done_o` rises in the cycle after the start edge.
- R3: Command cycle k drives `cmd_word_i[k*W +: W]`, where W is the bus width. The index k wraps after 32/W cycles, so on a 16-bit bus bits 15:0 go first and bits 31:16 second. Every dummy cycle drives zero. `wr_o` is high in every command and dummy cycle.
- R4: `dc_o` takes the level in `dc_lvl_i` bit 1 during the command phase, bit 2 during the dummy phase and bit 3 during the data phase. At all other times, including the done cycle, it takes bit 0.
- R5: `dc_o` lags the bus by `dc_dly_i` clock cycles, for values from 0 to DLY_MAX.
- R6: In counted mode (`stream_i` low) the data phase ends after (length + 1) bus cycles. A bus cycle counts only when `s_valid_i` is high. While `s_valid_i` is low, `wr_o` and `s_ready_o` stay low and the phase waits.
- R7: In streaming mode (`stream_i` high) the data phase forwards one bus cycle per cycle with `s_valid_i` high. It ends in the first data cycle where `s_valid_i` is low.
- R8: On a 16-bit bus each stream word takes one bus cycle, and `s_ready_o` is high with every data write. When `byte_swap_i` is set, the word goes out as {data[7:0], data[15:8]}.
- R9: On an 8-bit bus each word takes two bus cycles. The low byte goes first, or the high byte first when `ord8_i` is set. `s_ready_o` rises on the second byte, or on the final counted cycle if that comes earlier.
- R10: `bit_rev_i` mirrors the bit order of every data-phase bus word. Mirroring is applied after byte swap and byte selection. Command and dummy words are never changed.
- R11: `done_o` is high for exactly one cycle, the cycle after the last data-phase cycle. `busy_o` is low in the next cycle, and a start pulse sampled during the done cycle is ignored.
- R12: An abort pulse returns the block to idle in the next cycle without a done pulse, and a later start runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| abort_i | input | 1 | Abort pulse, returns the block to idle |
| phase_en_i | input | 3 | Phase enables: bit 0 command, bit 1 dummy, bit 2 data |
| cmd_len_i | input | CNT_W | Command phase cycles minus one |
| dum_len_i | input | CNT_W | Dummy phase cycles minus one |
| dat_len_i | input | CNT_W | Data phase cycles minus one (counted mode) |
| cmd_word_i | input | 32 | Command word |
| dc_lvl_i | input | 4 | Select-line levels: idle, command, dummy, data (bits 0 to 3) |
| dc_dly_i | input | clog2(DLY_MAX+1) | Select-line delay in clock cycles |
| stream_i | input | 1 | 1 = data phase follows the stream, 0 = counted |
| byte_swap_i | input | 1 | Exchange the bytes of each data word |
| ord8_i | input | 1 | 8-bit bus: send the high byte first |
| bit_rev_i | input | 1 | Mirror the bits of each data bus word |
| s_valid_i | input | 1 | Stream word valid |
| s_data_i | input | 16 | Stream word |
| s_ready_o | output | 1 | Stream word consumed |
| bus_o | output | BUS_W | Parallel bus word |
| wr_o | output | 1 | Write strobe, high in each bus cycle |
| dc_o | output | 1 | Data/command select line |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Most internal faults show up as a phase that is too long, too short or out of place. A wrong cycle counter or a wrong next-phase choice moves the done pulse and the dummy-zero cycles by at least one clock within the same transaction, so exact per-cycle checks of `bus_o`, `dc_o` and `done_o` catch them immediately. A stuck byte-lane toggle on the 8-bit bus shows up on the second data cycle as a repeated byte and a misplaced `s_ready_o`. A broken snapshot of the configuration shows up only when inputs change in the middle of a transaction, so the directed scenarios change them on purpose. A delay-line fault shifts `dc_o` edges against the strobe by whole cycles, and these edges are checked in each cycle around the phase boundaries.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   typedef enum logic [2:0] {
      PS_IDLE = 3'd0,
      PS_CMD  = 3'd1,
      PS_DUM  = 3'd2,
      PS_DAT  = 3'd3,
      PS_FIN  = 3'd4
   } pseq_state_e;

   // First enabled phase that follows 'cur'; FIN once none is left.
   function automatic pseq_state_e next_phase(pseq_state_e cur, logic [2:0] en);
      pseq_state_e nxt;
      nxt = PS_FIN;
      unique case (cur)
         PS_IDLE: nxt = en[0] ? PS_CMD : (en[1] ? PS_DUM : (en[2] ? PS_DAT : PS_FIN));
         PS_CMD:  nxt = en[1] ? PS_DUM : (en[2] ? PS_DAT : PS_FIN);
         PS_DUM:  nxt = en[2] ? PS_DAT : PS_FIN;
         default: nxt = PS_FIN;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/pbus_phase_fsm.sv
module pbus_phase_fsm
   import pbus_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             abort_i,
   input  logic [2:0]       en_live_i,
   input  logic [2:0]       en_q_i,
   input  logic [CNT_W-1:0] cmd_len_i,
   input  logic [CNT_W-1:0] dum_len_i,
   input  logic [CNT_W-1:0] dat_len_i,
   input  logic             stream_i,
   input  logic             s_valid_i,
   output pseq_state_e      state_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             half_o,
   output logic             dat_last_o
);

   pseq_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             half_q;

   assign dat_last_o = !stream_i && (cnt_q == dat_len_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE;
         cnt_q   <= '0;
         half_q  <= 1'b0;
      end else if (abort_i) begin
         state_q <= PS_IDLE;
         cnt_q   <= '0;
         half_q  <= 1'b0;
      end else begin
         unique case (state_q)
            PS_IDLE: begin
               if (start_i) state_q <= next_phase(PS_IDLE, en_live_i);
               cnt_q <= '0;
            end
            PS_CMD: begin
               if (cnt_q == cmd_len_i) begin
                  state_q <= next_phase(PS_CMD, en_q_i);
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PS_DUM: begin
               if (cnt_q == dum_len_i) begin
                  state_q <= next_phase(PS_DUM, en_q_i);
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PS_DAT: begin
               if (s_valid_i) half_q <= ~half_q;
               if (stream_i) begin
                  if (!s_valid_i) state_q <= PS_FIN;
               end else if (s_valid_i) begin
                  if (cnt_q == dat_len_i) begin
                     state_q <= PS_FIN;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               state_q <= PS_IDLE;
               cnt_q   <= '0;
               half_q  <= 1'b0;
            end
         endcase
      end
   end

   assign state_o = state_q;
   assign cnt_o   = cnt_q;
   assign half_o  = half_q;

endmodule

// File: rtl/pbus_data_fmt.sv
module pbus_data_fmt #(
   parameter int BUS_W = 16
) (
   input  logic [15:0]      word_i,
   input  logic             swap_i,
   input  logic             ord8_i,
   input  logic             rev_i,
   input  logic             half_i,
   output logic [BUS_W-1:0] bus_o,
   output logic             word_last_o
);

   logic [15:0]      swapped;
   logic [BUS_W-1:0] lane;
   logic [BUS_W-1:0] mirrored;

   assign swapped = swap_i ? {word_i[7:0], word_i[15:8]} : word_i;

   if (BUS_W == 16) begin : g_wide
      logic unused_narrow;
      assign unused_narrow = half_i ^ ord8_i;
      assign lane          = swapped;
      assign word_last_o   = 1'b1;
   end else begin : g_narrow
      assign lane        = (half_i ^ ord8_i) ? swapped[15:8] : swapped[7:0];
      assign word_last_o = half_i;
   end

   for (genvar b = 0; b < BUS_W; b++) begin : g_mirror
      assign mirrored[b] = lane[BUS_W-1-b];
   end

   assign bus_o = rev_i ? mirrored : lane;

endmodule

// File: rtl/pbus_dc_delay.sv
module pbus_dc_delay #(
   parameter int DLY_MAX = 3,
   localparam int DLY_W = $clog2(DLY_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             dc_o
);

   logic [DLY_MAX-1:0] line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '0;
      else        line_q <= {line_q[DLY_MAX-2:0], raw_i};
   end

   always_comb begin
      dc_o = raw_i;
      for (int i = 0; i < DLY_MAX; i++) begin
         if (dly_i == DLY_W'(i + 1)) dc_o = line_q[i];
      end
   end

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
   import pbus_pkg::*;
#(
   parameter int BUS_W   = 16,
   parameter int CNT_W   = 8,
   parameter int DLY_MAX = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start_i,
   input  logic                             abort_i,
   input  logic [2:0]                       phase_en_i,
   input  logic [CNT_W-1:0]                 cmd_len_i,
   input  logic [CNT_W-1:0]                 dum_len_i,
   input  logic [CNT_W-1:0]                 dat_len_i,
   input  logic [31:0]                      cmd_word_i,
   input  logic [3:0]                       dc_lvl_i,
   input  logic [$clog2(DLY_MAX+1)-1:0]     dc_dly_i,
   input  logic                             stream_i,
   input  logic                             byte_swap_i,
   input  logic                             ord8_i,
   input  logic                             bit_rev_i,
   input  logic                             s_valid_i,
   input  logic [15:0]                      s_data_i,
   output logic                             s_ready_o,
   output logic [BUS_W-1:0]                 bus_o,
   output logic                             wr_o,
   output logic                             dc_o,
   output logic                             busy_o,
   output logic                             done_o
);

   localparam int NSL  = 32 / BUS_W;
   localparam int SL_W = $clog2(NSL);

   if (!(BUS_W == 8 || BUS_W == 16)) begin : g_bad_bus
      $error("pbus_seq: BUS_W must be 8 or 16");
   end
   if (CNT_W < SL_W) begin : g_bad_cnt
      $error("pbus_seq: CNT_W too small for command slicing");
   end
   if (DLY_MAX < 2) begin : g_bad_dly
      $error("pbus_seq: DLY_MAX must be at least 2");
   end

   // configuration snapshot taken on an accepted start
   logic [2:0]       en_q;
   logic [CNT_W-1:0] cmd_len_q, dum_len_q, dat_len_q;
   logic [31:0]      cmd_q;
   logic [3:0]       lvl_q;
   logic             stream_q, swap_q, ord8_q, rev_q;

   pseq_state_e      state;
   logic [CNT_W-1:0] cnt;
   logic             half, dat_last, word_last, accept, dc_raw;
   logic [BUS_W-1:0] data_word;
   logic [BUS_W-1:0] cmd_sl [NSL];

   assign accept = start_i && !abort_i && (state == PS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= '0;
         cmd_len_q <= '0;
         dum_len_q <= '0;
         dat_len_q <= '0;
         cmd_q     <= '0;
         lvl_q     <= '0;
         stream_q  <= 1'b0;
         swap_q    <= 1'b0;
         ord8_q    <= 1'b0;
         rev_q     <= 1'b0;
      end else if (accept) begin
         en_q      <= phase_en_i;
         cmd_len_q <= cmd_len_i;
         dum_len_q <= dum_len_i;
         dat_len_q <= dat_len_i;
         cmd_q     <= cmd_word_i;
         lvl_q     <= dc_lvl_i;
         stream_q  <= stream_i;
         swap_q    <= byte_swap_i;
         ord8_q    <= ord8_i;
         rev_q     <= bit_rev_i;
      end
   end

   pbus_phase_fsm #(.CNT_W(CNT_W)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (accept),
      .abort_i    (abort_i),
      .en_live_i  (phase_en_i),
      .en_q_i     (en_q),
      .cmd_len_i  (cmd_len_q),
      .dum_len_i  (dum_len_q),
      .dat_len_i  (dat_len_q),
      .stream_i   (stream_q),
      .s_valid_i  (s_valid_i),
      .state_o    (state),
      .cnt_o      (cnt),
      .half_o     (half),
      .dat_last_o (dat_last)
   );

   pbus_data_fmt #(.BUS_W(BUS_W)) i_fmt (
      .word_i      (s_data_i),
      .swap_i      (swap_q),
      .ord8_i      (ord8_q),
      .rev_i       (rev_q),
      .half_i      (half),
      .bus_o       (data_word),
      .word_last_o (word_last)
   );

   for (genvar k = 0; k < NSL; k++) begin : g_cmd_slice
      assign cmd_sl[k] = cmd_q[k*BUS_W +: BUS_W];
   end

   always_comb begin
      bus_o  = '0;
      wr_o   = 1'b0;
      dc_raw = dc_lvl_i[0];
      unique case (state)
         PS_CMD: begin
            bus_o  = cmd_sl[cnt[SL_W-1:0]];
            wr_o   = 1'b1;
            dc_raw = lvl_q[1];
         end
         PS_DUM: begin
            wr_o   = 1'b1;
            dc_raw = lvl_q[2];
         end
         PS_DAT: begin
            bus_o  = data_word;
            wr_o   = s_valid_i;
            dc_raw = lvl_q[3];
         end
         default: ;
      endcase
   end

   assign s_ready_o = (state == PS_DAT) && s_valid_i && (word_last || dat_last);
   assign busy_o    = (state != PS_IDLE);
   assign done_o    = (state == PS_FIN);

   pbus_dc_delay #(.DLY_MAX(DLY_MAX)) i_dcdly (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (dc_raw),
      .dly_i (dc_dly_i),
      .dc_o  (dc_o)
   );

endmodule

// File: rtl/pbus_seq_chk.sv
module pbus_seq_chk #(
   parameter int BUS_W   = 16,
   parameter int CNT_W   = 8,
   parameter int DLY_MAX = 3
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         start_i,
   input logic                         abort_i,
   input logic [3:0]                   dc_lvl_i,
   input logic [$clog2(DLY_MAX+1)-1:0] dc_dly_i,
   input logic                         s_valid_i,
   input logic                         s_ready_o,
   input logic                         wr_o,
   input logic                         dc_o,
   input logic                         busy_o,
   input logic                         done_o
);

   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r11_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   a_r6_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> (s_valid_i && wr_o));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!wr_o && !s_ready_o));

   a_r1_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !abort_i && !busy_o) |=> busy_o);

   a_r12_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!busy_o && !done_o));

   a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && dc_dly_i == '0) |-> (dc_o == dc_lvl_i[0]));

endmodule

bind pbus_seq pbus_seq_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W), .DLY_MAX(DLY_MAX)) i_pbus_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .abort_i   (abort_i),
   .dc_lvl_i  (dc_lvl_i),
   .dc_dly_i  (dc_dly_i),
   .s_valid_i (s_valid_i),
   .s_ready_o (s_ready_o),
   .wr_o      (wr_o),
   .dc_o      (dc_o),
   .busy_o    (busy_o),
   .done_o    (done_o)
);

// File: tb/test_pbus_seq.sv
module test_pbus_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, abort_i = 1'b0;
   logic [2:0]  phase_en_i = '0;
   logic [7:0]  cmd_len_i = '0, dum_len_i = '0, dat_len_i = '0;
   logic [31:0] cmd_word_i = 32'hA1B2C3D4;
   logic [3:0]  dc_lvl_i = '0;
   logic [1:0]  dc_dly_i = '0;
   logic        stream_i = 1'b0, byte_swap_i = 1'b0, ord8_i = 1'b0, bit_rev_i = 1'b0;
   logic        s_valid_i = 1'b0;
   logic [15:0] s_data_i = 16'h1234;

   logic        rdy16, wr16, dc16, busy16, done16;
   logic [15:0] bus16;
   logic        rdy8, wr8, dc8, busy8, done8;
   logic [7:0]  bus8;

   int ntot = 0, nbad = 0, cyc = 0;
   bit wd_fired = 0;

   always #10 clk = ~clk;

   pbus_seq #(.BUS_W(16)) i_pbus_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .phase_en_i(phase_en_i), .cmd_len_i(cmd_len_i), .dum_len_i(dum_len_i),
      .dat_len_i(dat_len_i), .cmd_word_i(cmd_word_i), .dc_lvl_i(dc_lvl_i),
      .dc_dly_i(dc_dly_i), .stream_i(stream_i), .byte_swap_i(byte_swap_i),
      .ord8_i(ord8_i), .bit_rev_i(bit_rev_i), .s_valid_i(s_valid_i),
      .s_data_i(s_data_i), .s_ready_o(rdy16), .bus_o(bus16), .wr_o(wr16),
      .dc_o(dc16), .busy_o(busy16), .done_o(done16));

   pbus_seq #(.BUS_W(8)) i_pbus_seq_b8 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .phase_en_i(phase_en_i), .cmd_len_i(cmd_len_i), .dum_len_i(dum_len_i),
      .dat_len_i(dat_len_i), .cmd_word_i(cmd_word_i), .dc_lvl_i(dc_lvl_i),
      .dc_dly_i(dc_dly_i), .stream_i(stream_i), .byte_swap_i(byte_swap_i),
      .ord8_i(ord8_i), .bit_rev_i(bit_rev_i), .s_valid_i(s_valid_i),
      .s_data_i(s_data_i), .s_ready_o(rdy8), .bus_o(bus8), .wr_o(wr8),
      .dc_o(dc8), .busy_o(busy8), .done_o(done8));

   function automatic logic [15:0] mirror16(logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   function automatic logic [7:0] mirror8(logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      ntot++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic go();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic set_cfg(logic [2:0] en, logic [7:0] cl, logic [7:0] dl, logic [7:0] tl,
                          logic strm, logic swp, logic o8, logic rv, logic [3:0] lv);
      phase_en_i = en; cmd_len_i = cl; dum_len_i = dl; dat_len_i = tl;
      stream_i = strm; byte_swap_i = swp; ord8_i = o8; bit_rev_i = rv; dc_lvl_i = lv;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !wd_fired) begin
         wd_fired = 1;
         ntot++; nbad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", ntot, nbad);
         $finish;
      end
   end

   task automatic t_reset();
      chk("R1 reset busy16", busy16, 0);
      chk("R1 reset done16", done16, 0);
      chk("R1 reset wr16", wr16, 0);
      chk("R1 reset busy8", busy8, 0);
      chk("R1 reset rdy8", rdy8, 0);
   endtask

   task automatic t_full();
      logic [7:0] exp8 [3] = '{8'h34, 8'h12, 8'h34};
      set_cfg(3'b111, 8'd1, 8'd0, 8'd2, 0, 0, 0, 0, 4'b1010);
      s_valid_i = 1'b1; s_data_i = 16'h1234;
      go();
      chk("R1 busy at cmd", busy16, 1);
      chk("R3 cmd lo16", bus16, 16'hC3D4);
      chk("R3 cmd b0 8", bus8, 8'hD4);
      chk("R4 dc cmd", dc16, 1);
      chk("R3 wr cmd", wr16, 1);
      step();
      chk("R3 cmd hi16", bus16, 16'hA1B2);
      chk("R3 cmd b1 8", bus8, 8'hC3);
      step();
      chk("R3 dummy zero16", bus16, 0);
      chk("R3 dummy zero8", bus8, 0);
      chk("R4 dc dummy", dc16, 0);
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R8 data16", bus16, 16'h1234);
         chk("R8 ready16", rdy16, 1);
         chk("R4 dc data", dc16, 1);
         chk("R9 data8", bus8, exp8[i]);
         chk("R9 ready8", rdy8, (i != 0));
      end
      step();
      chk("R11 done16", done16, 1);
      chk("R11 done8", done8, 1);
      chk("R4 dc at done", dc16, 0);
      chk("R11 no wr at done", wr16, 0);
      step();
      chk("R11 idle after done", busy16, 0);
      chk("R11 done low", done16, 0);
   endtask

   task automatic t_format();
      set_cfg(3'b100, 8'd0, 8'd0, 8'd1, 0, 1, 1, 0, 4'b0000);
      s_valid_i = 1'b1; s_data_i = 16'h1234;
      go();
      chk("R8 swap16", bus16, 16'h3412);
      chk("R9 ord8 first", bus8, 8'h34);
      step();
      chk("R9 ord8 second", bus8, 8'h12);
      step();
      chk("R2 done after data", done16, 1);
      step();
      set_cfg(3'b101, 8'd0, 8'd0, 8'd1, 0, 0, 0, 1, 4'b0000);
      go();
      chk("R10 cmd not mirrored", bus16, 16'hC3D4);
      step();
      chk("R10 mirror16", bus16, mirror16(16'h1234));
      chk("R10 mirror8 lo", bus8, mirror8(8'h34));
      step();
      chk("R10 mirror8 hi", bus8, mirror8(8'h12));
      step();
      chk("R11 done", done16, 1);
      step();
   endtask

   task automatic t_stall();
      set_cfg(3'b100, 8'd0, 8'd0, 8'd1, 0, 0, 0, 0, 4'b0000);
      s_valid_i = 1'b0;
      go();
      chk("R6 stall wr", wr16, 0);
      chk("R6 stall ready", rdy16, 0);
      step();
      chk("R6 still busy", busy16, 1);
      chk("R6 no early done", done16, 0);
      s_valid_i = 1'b1;
      #1;
      chk("R6 resume wr", wr16, 1);
      chk("R6 resume 8", bus8, 8'h34);
      step();
      chk("R6 second 8", bus8, 8'h12);
      step();
      chk("R6 done after count", done16, 1);
      chk("R6 done 8", done8, 1);
      step();
   endtask

   task automatic t_stream();
      set_cfg(3'b100, 8'd0, 8'd0, 8'd0, 1, 0, 0, 0, 4'b0000);
      s_valid_i = 1'b1;
      go();
      for (int i = 0; i < 4; i++) begin
         chk("R7 stream wr", wr16, 1);
         chk("R7 stream busy", busy16, 1);
         chk("R9 stream ready8", rdy8, (i % 2 == 1));
         step();
      end
      s_valid_i = 1'b0;
      #1;
      chk("R7 valid low no wr", wr16, 0);
      chk("R7 not done yet", done16, 0);
      step();
      chk("R7 done16", done16, 1);
      chk("R7 done8", done8, 1);
      step();
   endtask

   task automatic t_skip();
      set_cfg(3'b000, 8'd3, 8'd3, 8'd3, 0, 0, 0, 0, 4'b0001);
      go();
      chk("R2 empty done", done16, 1);
      chk("R4 idle level at done", dc16, 1);
      step();
      chk("R4 idle level", dc16, 1);
      set_cfg(3'b101, 8'd0, 8'd0, 8'd0, 0, 0, 0, 0, 4'b1010);
      s_valid_i = 1'b1;
      go();
      chk("R2 cmd first", bus16, 16'hC3D4);
      step();
      chk("R2 dummy skipped", bus16, 16'h1234);
      chk("R2 dc data", dc16, 1);
      step();
      chk("R2 done", done16, 1);
      step();
   endtask

   task automatic t_delay();
      logic exp [6] = '{0, 0, 1, 1, 1, 0};
      set_cfg(3'b001, 8'd2, 8'd0, 8'd0, 0, 0, 0, 0, 4'b0010);
      dc_dly_i = 2'd2;
      repeat (4) step();
      go();
      for (int i = 0; i < 6; i++) begin
         chk("R5 delayed dc16", dc16, exp[i]);
         chk("R5 delayed dc8", dc8, exp[i]);
         step();
      end
      dc_dly_i = 2'd0;
      repeat (4) step();
   endtask

   task automatic t_restart();
      set_cfg(3'b001, 8'd3, 8'd0, 8'd0, 0, 0, 0, 0, 4'b0000);
      go();
      start_i = 1'b1; cmd_len_i = 8'd0;
      step();
      start_i = 1'b0;
      step(); step();
      chk("R1 snapshot keeps length", done16, 0);
      step();
      chk("R11 done after 4", done16, 1);
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      chk("R11 start in done ignored", busy16, 0);
      step();
   endtask

   task automatic t_abort();
      set_cfg(3'b001, 8'd5, 8'd0, 8'd0, 0, 0, 0, 0, 4'b0000);
      go();
      abort_i = 1'b1;
      step();
      abort_i = 1'b0;
      chk("R12 abort idle", busy16, 0);
      chk("R12 abort no done", done16, 0);
      step();
      chk("R12 still no done", done16, 0);
      set_cfg(3'b000, 8'd0, 8'd0, 8'd0, 0, 0, 0, 0, 4'b0000);
      go();
      chk("R12 restart works", done16, 1);
      step();
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_full();
      t_format();
      t_stall();
      t_stream();
      t_skip();
      t_delay();
      t_restart();
      t_abort();
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end

endmodule